// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, for each address phase seen by a two-sided bus bridge, whether the bridge claims the access. An access carries an address, a memory or I/O type and the side it appeared on (primary or secondary). The decoder tests it against a standard memory window with 1 MB granularity, a standard I/O window with 4 KB granularity, and a set of extension windows. Each extension window has a finer granularity (4 KB for memory, doubleword for I/O), its own kind, and its own decode side.

Each side has its own decode mode. Positive mode claims inside the standard windows. Negative mode claims outside them. Subtractive mode claims only an access that nobody else has taken, judged a fixed number of cycles after the address phase. An extension window can also punch a hole into primary decoding. The result is a registered one-cycle claim pulse, a code for what caused the claim, and flags for the extension windows that matched.

Top module: `bridge_window_decode`

## Requirements
- R1: While reset is held, and in the first cycle after it, `claim` is 0, `claim_src` is 0 and `claim_ext` is 0.
- R2: Each side's 2-bit mode is decoded as follows: 00 selects that side's natural mode (positive on primary, side 0; negative on secondary, side 1), 01 selects positive, 10 selects negative and 11 selects subtractive.
- R3: In positive mode an access is claimed when its address lies inside the standard window of its own type (`req_io`=0 memory, 1 I/O). The claim appears in the cycle after the address phase with `claim_src`=1.
- R4: In negative mode an access is claimed when its address lies outside the standard window of its own type. The claim appears in the cycle after the address phase with `claim_src`=2.
- R5: Window bounds are inclusive. The standard memory base and limit give address bits 31:20. The standard I/O base and limit give bits 31:12. The base is rounded down to the granularity and the limit is rounded up.
- R6: Extension window kinds are 00 off, 01 prefetchable memory, 10 nonprefetchable memory and 11 I/O. Memory kinds compare bits 31:12 and I/O compares bits 31:2, with inclusive rounded bounds.
- R7: A window whose `ext_side` equals the access side and which matches claims the access in every mode. It takes precedence over the standard result, gives `claim_src`=3, and sets bit i of `claim_ext` for each such window i.
- R8: On the primary side, a matching extension window with its `ext_hole` bit set removes the standard window match. The access then counts as outside the standard window.
- R9: A window whose base exceeds its limit never matches. This applies to the standard windows and to the extension windows.
- R10: In subtractive mode with no extension claim, the access is claimed with `claim_src`=4 in the cycle after the third clock edge that follows the address phase, if `none_claimed` is 1 at that third edge.
- R11: A subtractive access with `none_claimed` at 0 at that third edge is not claimed, whatever its value in the cycles before. An access that an extension window already claimed produces no later subtractive claim.
- R12: `claim` is a one-cycle pulse per address phase. Whenever `claim` is 0, `claim_src` and `claim_ext` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address phase strobe, one cycle |
| req_addr | input | ADDR_W | Access address |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_side | input | 1 | 0 = primary side, 1 = secondary side |
| none_claimed | input | 1 | High while no other device has claimed the access |
| mode_pri | input | 2 | Primary side decode mode |
| mode_sec | input | 2 | Secondary side decode mode |
| std_mem_base | input | ADDR_W-20 | Standard memory window base, upper address bits |
| std_mem_limit | input | ADDR_W-20 | Standard memory window limit, upper address bits |
| std_io_base | input | ADDR_W-12 | Standard I/O window base, upper address bits |
| std_io_limit | input | ADDR_W-12 | Standard I/O window limit, upper address bits |
| ext_base | input | NUM_EXT x ADDR_W | Extension window base addresses |
| ext_limit | input | NUM_EXT x ADDR_W | Extension window limit addresses |
| ext_kind | input | NUM_EXT x 2 | Extension window kind |
| ext_side | input | NUM_EXT | Decode side of each extension window |
| ext_hole | input | NUM_EXT | Exclude window from primary standard decoding |
| claim | output | 1 | Claim pulse |
| claim_src | output | 3 | Claim cause: 0 none, 1 positive, 2 negative, 3 extension, 4 subtractive |
| claim_ext | output | NUM_EXT | Extension windows that caused the claim |

## Verification
The assertions check, on every cycle, that the output fields agree with the claim pulse. They also check that a non-subtractive claim comes exactly one cycle after an address phase. A subtractive claim must come exactly the programmed delay later, and only when the no-other-claim input was high at the deciding edge. Which addresses fall inside which window can only be shown by the bench's scenarios. The same holds for rounding at the window edges, the effect of a hole, disabled windows and the per-side mode selection, which the bench drives with known configurations and addresses.

// File: rtl/bwd_pkg.sv
// Package: shared codes for the bridge window decoder.
// Assumes a 3-bit claim cause field and 2-bit mode / kind fields.
package bwd_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_POS  = 3'd1,
        SRC_NEG  = 3'd2,
        SRC_EXT  = 3'd3,
        SRC_SUB  = 3'd4
    } claim_src_e;

    localparam logic [1:0] MODE_NATURAL = 2'b00;
    localparam logic [1:0] MODE_POS     = 2'b01;
    localparam logic [1:0] MODE_NEG     = 2'b10;
    localparam logic [1:0] MODE_SUB     = 2'b11;

    localparam logic [1:0] KIND_OFF     = 2'b00;
    localparam logic [1:0] KIND_MEM_PF  = 2'b01;
    localparam logic [1:0] KIND_MEM_NP  = 2'b10;
    localparam logic [1:0] KIND_IO      = 2'b11;

endpackage

// File: rtl/bwd_range_match.sv
// Inclusive address range compare at a given granularity.
// Base is rounded down and limit rounded up to 2**LSB bytes; a base
// above the limit never matches. Purely combinational.
module bwd_range_match #(
    parameter int ADDR_W = 32,
    parameter int LSB    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic              en,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << LSB) - ADDR_W'(1);

    logic [ADDR_W-1:0] base_dn;
    logic [ADDR_W-1:0] limit_up;

    // Round the bounds to the granularity and compare inclusively.
    always_comb begin
        base_dn  = base & ~LOW_MASK;
        limit_up = limit | LOW_MASK;
        hit      = en && (base_dn <= limit_up) &&
                   (addr >= base_dn) && (addr <= limit_up);
    end
endmodule

// File: rtl/bwd_ext_window.sv
// One extension window: chooses memory or I/O granularity by kind and
// reports a match only when the access type agrees with the kind.
// Assumes kind encoding from bwd_pkg.
module bwd_ext_window #(
    parameter int ADDR_W  = 32,
    parameter int MEM_LSB = 12,
    parameter int IO_LSB  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [1:0]        kind,
    output logic              hit
);
    import bwd_pkg::*;

    logic mem_en;
    logic io_en;
    logic mem_hit;
    logic io_hit;

    // Enable the comparator whose kind and access type agree.
    always_comb begin
        mem_en = !req_io && (kind == KIND_MEM_PF || kind == KIND_MEM_NP);
        io_en  = req_io && (kind == KIND_IO);
    end

    bwd_range_match #(.ADDR_W(ADDR_W), .LSB(MEM_LSB)) u_mem (
        .addr(addr), .base(base), .limit(limit), .en(mem_en), .hit(mem_hit)
    );

    bwd_range_match #(.ADDR_W(ADDR_W), .LSB(IO_LSB)) u_io (
        .addr(addr), .base(base), .limit(limit), .en(io_en), .hit(io_hit)
    );

    // Either enabled comparator reporting a match is a window hit.
    always_comb hit = mem_hit || io_hit;
endmodule

// File: rtl/bwd_side_policy.sv
// Resolves the decode mode of the access side and turns the standard
// window result into a positive or negative claim. Subtractive mode
// yields no immediate claim and is flagged for the delay timer.
module bwd_side_policy (
    input  logic                 req_side,
    input  logic [1:0]           mode_pri,
    input  logic [1:0]           mode_sec,
    input  logic                 range_hit,
    output logic                 sub_mode,
    output logic                 base_claim,
    output bwd_pkg::claim_src_e  base_src
);
    import bwd_pkg::*;

    logic [1:0] raw_mode;
    logic [1:0] eff_mode;

    // Pick the side's mode and map the natural code per side.
    always_comb begin
        raw_mode = req_side ? mode_sec : mode_pri;
        if (raw_mode == MODE_NATURAL) eff_mode = req_side ? MODE_NEG : MODE_POS;
        else                          eff_mode = raw_mode;
    end

    // Convert the window result into a claim for the effective mode.
    always_comb begin
        sub_mode   = (eff_mode == MODE_SUB);
        base_claim = 1'b0;
        base_src   = SRC_NONE;
        unique case (eff_mode)
            MODE_POS: if (range_hit)  begin base_claim = 1'b1; base_src = SRC_POS; end
            MODE_NEG: if (!range_hit) begin base_claim = 1'b1; base_src = SRC_NEG; end
            default: ;
        endcase
    end
endmodule

// File: rtl/bwd_sub_timer.sv
// Subtractive delay timer: armed by an address phase in subtractive mode,
// fires on the DELAY-th edge after it when none_claimed is high there.
// Any new address phase restarts or clears it.
module bwd_sub_timer #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic arm,
    input  logic none_claimed,
    output logic fire
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    // Load on an address phase, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (req_valid)      cnt <= arm ? CW'(DELAY) : '0;
        else if (cnt != '0)      cnt <= cnt - CW'(1);
    end

    // The last count is the deciding edge.
    always_comb fire = (cnt == CW'(1)) && none_claimed;
endmodule

// File: rtl/bridge_window_decode.sv
// Bridge address window decoder top. Matches each address phase against
// the standard memory / I/O windows and NUM_EXT extension windows, applies
// the side's decode mode, and registers a one-cycle claim result.
// Assumes req_valid lasts one cycle per address phase; configuration
// inputs are stable while accesses are in flight.
module bridge_window_decode #(
    parameter int ADDR_W      = 32,
    parameter int NUM_EXT     = 2,
    parameter int STD_MEM_LSB = 20,
    parameter int STD_IO_LSB  = 12,
    parameter int EXT_MEM_LSB = 12,
    parameter int EXT_IO_LSB  = 2,
    parameter int SUB_DELAY   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic                              req_io,
    input  logic                              req_side,
    input  logic                              none_claimed,
    input  logic [1:0]                        mode_pri,
    input  logic [1:0]                        mode_sec,
    input  logic [ADDR_W-STD_MEM_LSB-1:0]     std_mem_base,
    input  logic [ADDR_W-STD_MEM_LSB-1:0]     std_mem_limit,
    input  logic [ADDR_W-STD_IO_LSB-1:0]      std_io_base,
    input  logic [ADDR_W-STD_IO_LSB-1:0]      std_io_limit,
    input  logic [NUM_EXT-1:0][ADDR_W-1:0]    ext_base,
    input  logic [NUM_EXT-1:0][ADDR_W-1:0]    ext_limit,
    input  logic [NUM_EXT-1:0][1:0]           ext_kind,
    input  logic [NUM_EXT-1:0]                ext_side,
    input  logic [NUM_EXT-1:0]                ext_hole,
    output logic                              claim,
    output logic [2:0]                        claim_src,
    output logic [NUM_EXT-1:0]                claim_ext
);
    import bwd_pkg::*;

    logic               std_mem_hit;
    logic               std_io_hit;
    logic               std_hit;
    logic               hole_hit;
    logic               range_hit;
    logic [NUM_EXT-1:0] ext_hit;
    logic [NUM_EXT-1:0] ext_sel;
    logic               sub_mode;
    logic               base_claim;
    claim_src_e         base_src;
    logic               fast_claim;
    claim_src_e         fast_src;
    logic               sub_arm;
    logic               sub_fire;

    // Standard windows, widened to full addresses.
    bwd_range_match #(.ADDR_W(ADDR_W), .LSB(STD_MEM_LSB)) u_std_mem (
        .addr (req_addr),
        .base ({std_mem_base,  {STD_MEM_LSB{1'b0}}}),
        .limit({std_mem_limit, {STD_MEM_LSB{1'b0}}}),
        .en   (!req_io),
        .hit  (std_mem_hit)
    );

    bwd_range_match #(.ADDR_W(ADDR_W), .LSB(STD_IO_LSB)) u_std_io (
        .addr (req_addr),
        .base ({std_io_base,  {STD_IO_LSB{1'b0}}}),
        .limit({std_io_limit, {STD_IO_LSB{1'b0}}}),
        .en   (req_io),
        .hit  (std_io_hit)
    );

    // Extension windows, one matcher each.
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        bwd_ext_window #(
            .ADDR_W(ADDR_W), .MEM_LSB(EXT_MEM_LSB), .IO_LSB(EXT_IO_LSB)
        ) u_win (
            .addr  (req_addr),
            .req_io(req_io),
            .base  (ext_base[i]),
            .limit (ext_limit[i]),
            .kind  (ext_kind[i]),
            .hit   (ext_hit[i])
        );
    end

    // Combine standard hits, apply primary holes, select side-matched extensions.
    always_comb begin
        std_hit   = std_mem_hit || std_io_hit;
        hole_hit  = !req_side && ((ext_hit & ext_hole) != '0);
        range_hit = std_hit && !hole_hit;
        ext_sel   = ext_hit & ~(ext_side ^ {NUM_EXT{req_side}});
    end

    bwd_side_policy u_policy (
        .req_side  (req_side),
        .mode_pri  (mode_pri),
        .mode_sec  (mode_sec),
        .range_hit (range_hit),
        .sub_mode  (sub_mode),
        .base_claim(base_claim),
        .base_src  (base_src)
    );

    // Extension claims outrank the standard result; subtractive waits.
    always_comb begin
        if (ext_sel != '0) begin
            fast_claim = 1'b1;
            fast_src   = SRC_EXT;
        end else begin
            fast_claim = base_claim;
            fast_src   = base_src;
        end
        sub_arm = sub_mode && (ext_sel == '0);
    end

    bwd_sub_timer #(.DELAY(SUB_DELAY)) u_sub (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .arm         (sub_arm),
        .none_claimed(none_claimed),
        .fire        (sub_fire)
    );

    // Register the claim pulse; a new address phase takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim     <= 1'b0;
            claim_src <= SRC_NONE;
            claim_ext <= '0;
        end else if (req_valid) begin
            claim     <= fast_claim;
            claim_src <= fast_src;
            claim_ext <= (fast_src == SRC_EXT) ? ext_sel : '0;
        end else if (sub_fire) begin
            claim     <= 1'b1;
            claim_src <= SRC_SUB;
            claim_ext <= '0;
        end else begin
            claim     <= 1'b0;
            claim_src <= SRC_NONE;
            claim_ext <= '0;
        end
    end
endmodule

// File: rtl/bwd_checker.sv
// Protocol checker for bridge_window_decode, attached by bind.
// Tracks cycles since the last address phase to judge claim timing.
module bwd_checker #(
    parameter int NUM_EXT   = 2,
    parameter int SUB_DELAY = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               none_claimed,
    input logic               claim,
    input logic [2:0]         claim_src,
    input logic [NUM_EXT-1:0] claim_ext
);
    localparam int CW = $clog2(SUB_DELAY + 3);
    localparam logic [CW-1:0] SAT = CW'(SUB_DELAY + 2);

    logic [CW-1:0] since;

    // Count edges since the latest address phase, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                           since <= '0;
        else if (req_valid)                   since <= CW'(1);
        else if (since != '0 && since != SAT) since <= since + CW'(1);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!claim && claim_src == 3'd0 && claim_ext == '0));

    assert_idle_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> (claim_src == 3'd0 && claim_ext == '0));

    assert_claim_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (claim_src != 3'd0 && claim_src <= 3'd4));

    assert_ext_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_src == 3'd3) |-> (claim_ext != '0));

    assert_ext_flags_only_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_src != 3'd3) |-> (claim_ext == '0));

    assert_fast_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_src != 3'd4) |-> (since == CW'(1)));

    assert_sub_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_src == 3'd4) |-> (since == CW'(SUB_DELAY + 1)));

    assert_sub_needs_free_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_src == 3'd4) |-> $past(none_claimed));
endmodule

bind bridge_window_decode bwd_checker #(
    .NUM_EXT  (NUM_EXT),
    .SUB_DELAY(SUB_DELAY)
) u_bwd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .none_claimed(none_claimed),
    .claim       (claim),
    .claim_src   (claim_src),
    .claim_ext   (claim_ext)
);

// File: tb/tb_bridge_window_decode.sv
`timescale 1ns/1ps
module tb_bridge_window_decode;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr = '0;
    logic              req_io = 1'b0;
    logic              req_side = 1'b0;
    logic              none_claimed = 1'b0;
    logic [1:0]        mode_pri = 2'b00;
    logic [1:0]        mode_sec = 2'b00;
    logic [11:0]       std_mem_base = 12'h100;
    logic [11:0]       std_mem_limit = 12'h17F;
    logic [19:0]       std_io_base = 20'h00001;
    logic [19:0]       std_io_limit = 20'h00002;
    logic [1:0][31:0]  ext_base = '0;
    logic [1:0][31:0]  ext_limit = '0;
    logic [1:0][1:0]   ext_kind = '0;
    logic [1:0]        ext_side = '0;
    logic [1:0]        ext_hole = '0;
    logic              claim;
    logic [2:0]        claim_src;
    logic [1:0]        claim_ext;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [2:0] S_NONE = 3'd0, S_POS = 3'd1, S_NEG = 3'd2,
                           S_EXT = 3'd3, S_SUB = 3'd4;

    always #2.5 clk = ~clk;

    bridge_window_decode dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_io(req_io), .req_side(req_side), .none_claimed(none_claimed),
        .mode_pri(mode_pri), .mode_sec(mode_sec),
        .std_mem_base(std_mem_base), .std_mem_limit(std_mem_limit),
        .std_io_base(std_io_base), .std_io_limit(std_io_limit),
        .ext_base(ext_base), .ext_limit(ext_limit), .ext_kind(ext_kind),
        .ext_side(ext_side), .ext_hole(ext_hole),
        .claim(claim), .claim_src(claim_src), .claim_ext(claim_ext)
    );

    task automatic check(input string tag, input logic e_claim,
                         input logic [2:0] e_src, input logic [1:0] e_ext);
        n_chk++;
        if (claim !== e_claim || claim_src !== e_src || claim_ext !== e_ext) begin
            n_fail++;
            $display("FAIL %s: got claim=%0b src=%0d ext=%b, expected claim=%0b src=%0d ext=%b",
                     tag, claim, claim_src, claim_ext, e_claim, e_src, e_ext);
        end
    endtask

    // Drive one address phase; returns at the falling edge after it.
    task automatic access(input logic [31:0] a, input logic io, input logic side);
        @(negedge clk);
        req_addr = a; req_io = io; req_side = side; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 during reset", 1'b0, S_NONE, 2'b00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, S_NONE, 2'b00);
    endtask

    task automatic t_positive;
        // R3 / R5 / R2: primary natural mode is positive
        access(32'h1000_0000, 1'b0, 1'b0); check("R3 mem base", 1'b1, S_POS, 2'b00);
        access(32'h17FF_FFFF, 1'b0, 1'b0); check("R5 mem limit rounded up", 1'b1, S_POS, 2'b00);
        access(32'h0FFF_FFFF, 1'b0, 1'b0); check("R5 below mem base", 1'b0, S_NONE, 2'b00);
        access(32'h1800_0000, 1'b0, 1'b0); check("R5 above mem limit", 1'b0, S_NONE, 2'b00);
        access(32'h0000_1000, 1'b1, 1'b0); check("R3 io base", 1'b1, S_POS, 2'b00);
        access(32'h0000_2FFF, 1'b1, 1'b0); check("R5 io limit rounded up", 1'b1, S_POS, 2'b00);
        access(32'h0000_3000, 1'b1, 1'b0); check("R5 above io limit", 1'b0, S_NONE, 2'b00);
        access(32'h0000_1000, 1'b0, 1'b0); check("R3 type mismatch", 1'b0, S_NONE, 2'b00);
    endtask

    task automatic t_negative;
        // R4 / R2: secondary natural mode is negative
        access(32'h2000_0000, 1'b0, 1'b1); check("R4 outside claimed", 1'b1, S_NEG, 2'b00);
        access(32'h1234_5678, 1'b0, 1'b1); check("R4 inside not claimed", 1'b0, S_NONE, 2'b00);
        access(32'h0000_0FFC, 1'b1, 1'b1); check("R4 io outside", 1'b1, S_NEG, 2'b00);
    endtask

    task automatic t_modes;
        mode_pri = 2'b10; mode_sec = 2'b01;
        access(32'h2000_0000, 1'b0, 1'b0); check("R2 primary forced negative", 1'b1, S_NEG, 2'b00);
        access(32'h1000_0000, 1'b0, 1'b1); check("R2 secondary forced positive", 1'b1, S_POS, 2'b00);
        mode_pri = 2'b01;
        access(32'h2000_0000, 1'b0, 1'b0); check("R2 primary explicit positive", 1'b0, S_NONE, 2'b00);
        mode_pri = 2'b00; mode_sec = 2'b00;
    endtask

    task automatic t_ext;
        ext_base[0] = 32'h0000_0300; ext_limit[0] = 32'h0000_0303;
        ext_kind[0] = 2'b11; ext_side[0] = 1'b1;
        access(32'h0000_0300, 1'b1, 1'b1); check("R7 io ext base", 1'b1, S_EXT, 2'b01);
        access(32'h0000_0303, 1'b1, 1'b1); check("R6 io ext limit dword", 1'b1, S_EXT, 2'b01);
        access(32'h0000_0304, 1'b1, 1'b1); check("R6 io ext above limit", 1'b1, S_NEG, 2'b00);
        access(32'h0000_0300, 1'b0, 1'b1); check("R6 kind mismatch", 1'b1, S_NEG, 2'b00);
        access(32'h0000_0300, 1'b1, 1'b0); check("R7 wrong side", 1'b0, S_NONE, 2'b00);
        ext_base[1] = 32'h4000_0000; ext_limit[1] = 32'h4000_0000;
        ext_kind[1] = 2'b01; ext_side[1] = 1'b0;
        access(32'h4000_0FFF, 1'b0, 1'b0); check("R6 mem ext 4KB limit", 1'b1, S_EXT, 2'b10);
        access(32'h4000_1000, 1'b0, 1'b0); check("R6 mem ext above", 1'b0, S_NONE, 2'b00);
        ext_base[0] = 32'h4000_0000; ext_limit[0] = 32'h4000_0000;
        ext_kind[0] = 2'b10; ext_side[0] = 1'b0;
        access(32'h4000_0000, 1'b0, 1'b0); check("R7 both windows", 1'b1, S_EXT, 2'b11);
        ext_kind[1] = 2'b00;
        access(32'h4000_0000, 1'b0, 1'b0); check("R6 kind off", 1'b1, S_EXT, 2'b01);
        ext_kind[0] = 2'b00;
        access(32'h4000_0000, 1'b0, 1'b0); check("R6 all off", 1'b0, S_NONE, 2'b00);
    endtask

    task automatic t_hole;
        ext_base[0] = 32'h1200_0000; ext_limit[0] = 32'h1200_0000;
        ext_kind[0] = 2'b01; ext_side[0] = 1'b1; ext_hole[0] = 1'b1;
        access(32'h1200_0800, 1'b0, 1'b0); check("R8 hole blocks positive", 1'b0, S_NONE, 2'b00);
        access(32'h1200_1000, 1'b0, 1'b0); check("R8 past hole", 1'b1, S_POS, 2'b00);
        access(32'h1200_0800, 1'b0, 1'b1); check("R8 secondary ext claim", 1'b1, S_EXT, 2'b01);
        mode_pri = 2'b10;
        access(32'h1200_0800, 1'b0, 1'b0); check("R8 hole in negative", 1'b1, S_NEG, 2'b00);
        mode_pri = 2'b00; ext_hole[0] = 1'b0;
        access(32'h1200_0800, 1'b0, 1'b0); check("R8 no hole", 1'b1, S_POS, 2'b00);
        ext_kind[0] = 2'b00;
    endtask

    task automatic t_disabled;
        std_mem_base = 12'h180; std_mem_limit = 12'h17F;
        access(32'h1800_0000, 1'b0, 1'b0); check("R9 std mem disabled", 1'b0, S_NONE, 2'b00);
        access(32'h1000_0000, 1'b0, 1'b0); check("R9 std mem disabled low", 1'b0, S_NONE, 2'b00);
        mode_pri = 2'b10;
        access(32'h1000_0000, 1'b0, 1'b0); check("R9 disabled counts outside", 1'b1, S_NEG, 2'b00);
        mode_pri = 2'b00; std_mem_base = 12'h100;
        ext_base[0] = 32'h0000_0304; ext_limit[0] = 32'h0000_0300;
        ext_kind[0] = 2'b11; ext_side[0] = 1'b0;
        access(32'h0000_0302, 1'b1, 1'b0); check("R9 ext disabled", 1'b0, S_NONE, 2'b00);
        ext_kind[0] = 2'b00;
    endtask

    task automatic t_subtractive;
        mode_pri = 2'b11; none_claimed = 1'b0;
        access(32'h1000_0000, 1'b0, 1'b0); check("R10 no fast claim", 1'b0, S_NONE, 2'b00);
        @(negedge clk); check("R10 wait 1", 1'b0, S_NONE, 2'b00);
        @(negedge clk); check("R10 wait 2", 1'b0, S_NONE, 2'b00);
        none_claimed = 1'b1;
        @(negedge clk); check("R10 subtractive claim", 1'b1, S_SUB, 2'b00);
        none_claimed = 1'b0;
        @(negedge clk); check("R12 pulse ends", 1'b0, S_NONE, 2'b00);
        // R11: free earlier but taken at the deciding edge
        access(32'h2000_0000, 1'b0, 1'b0);
        @(negedge clk); none_claimed = 1'b1;
        @(negedge clk); none_claimed = 1'b0;
        @(negedge clk); check("R11 taken at decision", 1'b0, S_NONE, 2'b00);
        @(negedge clk); check("R11 stays quiet", 1'b0, S_NONE, 2'b00);
        // R11: extension claim suppresses later subtractive claim
        ext_base[1] = 32'h4000_0000; ext_limit[1] = 32'h4000_0000;
        ext_kind[1] = 2'b01; ext_side[1] = 1'b0;
        access(32'h4000_0000, 1'b0, 1'b0); check("R7 ext in subtractive", 1'b1, S_EXT, 2'b10);
        none_claimed = 1'b1;
        @(negedge clk); @(negedge clk);
        @(negedge clk); check("R11 no second claim", 1'b0, S_NONE, 2'b00);
        none_claimed = 1'b0; mode_pri = 2'b00; ext_kind[1] = 2'b00;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_positive();
        t_negative();
        t_modes();
        t_ext();
        t_hole();
        t_disabled();
        t_subtractive();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule